// File: doc/BRIEF.md
# Instruction Address Translation Buffer

This block maps instruction-fetch virtual addresses onto physical addresses with a small set-associative translation buffer. A lookup picks one set from the low bits of the virtual page number. It compares the upper tag of the address against every way of that set. The result is returned one clock later.

A clean hit returns the physical page joined with the page offset, plus the cache-inhibit attribute of the page. A hit that fails the execute-permission check for the current privilege level reports a page fault. No matching entry reports a miss, and the faulting address appears on the address output. When translation is switched off, or the unit is marked absent, the address passes straight through.

Each entry keeps a small usage down-counter. Every hit or fault ages the whole set and reloads the counter of the way that was used. Refill software writes and reads the tag and translate words through a register port that is addressed by way and set.

Top module: `itlb_lookup`

## Requirements
- R1: When `transEn` or `mmuPresent` is low, a lookup returns `paddr` equal to `vaddr`, with `hit`, `miss`, `pageFault` and `cacheInhibit` all low, and no entry is modified.
- R2: The set index is `vaddr[PAGE_BITS +: log2(NSETS)]` and the tag is the bits above it. A way hits only when its valid bit is set and its stored tag equals the lookup tag. Page-offset bits never affect matching.
- R3: On a clean hit, `paddr` is the entry's physical page number in bits [ADDR_W-1:PAGE_BITS], ORed with `vaddr[PAGE_BITS-1:0]`.
- R4: On a miss, `miss` is high, `paddr` equals `vaddr`, and no entry (tag, valid or usage counter) changes.
- R5: On a hit, the permission used is translate-word bit 1 in supervisor mode and bit 2 in user mode. If that bit is 0, `pageFault` is high, `hit` is low and `paddr` is zero.
- R6: `cacheInhibit` equals translate-word bit 0 of the hit way on a clean hit, and is 0 for every other outcome.
- R7: On a hit or page fault, every way of the set has its nonzero usage counter decremented by one. The used way's counter is then ORed with (NSETS-1) truncated to the counter width.
- R8: If several ways of a set match, the lowest-numbered way supplies the translation, the attributes and the counter reload.
- R9: Register port layouts are as follows. Tag word (`regSel`=0): tag in bits [ADDR_W-1:PAGE_BITS+log2(NSETS)], counter in bits [LRU_W:1], valid in bit 0. Translate word (`regSel`=1): page number in bits [ADDR_W-1:PAGE_BITS], user-execute in bit 2, supervisor-execute in bit 1, cache-inhibit in bit 0. All other bits read as zero. `regRdata` shows the addressed word combinationally. A write takes effect at the clock edge and overrides a counter update of the same entry in the same cycle.
- R10: Reset clears every valid bit and usage counter.
- R11: A lookup requested at a clock edge produces a one-cycle `lookupValid` after that edge, with exactly one or none of `hit`, `miss` and `pageFault` set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lookupReq | input | 1 | Start a lookup this cycle |
| vaddr | input | ADDR_W | Virtual fetch address |
| transEn | input | 1 | Translation enabled |
| mmuPresent | input | 1 | Translation unit implemented |
| supervisor | input | 1 | Current privilege is supervisor |
| regWe | input | 1 | Register write strobe |
| regSel | input | 1 | 0 selects the tag word, 1 selects the translate word |
| regWay | input | WAY_W | Way of the addressed entry |
| regSet | input | SET_W | Set of the addressed entry |
| regWdata | input | ADDR_W | Register write data |
| regRdata | output | ADDR_W | Addressed register contents |
| lookupValid | output | 1 | Lookup result valid |
| hit | output | 1 | Clean translation |
| miss | output | 1 | No matching entry |
| pageFault | output | 1 | Execute permission violated |
| cacheInhibit | output | 1 | Hit page is not cacheable |
| paddr | output | ADDR_W | Translated, passed-through or faulting address |

## Verification
The bench fills a set with two identical valid tags. A design without a fixed lowest-way priority would then return the wrong page number or reload the wrong counter. Counters are read back after every hit and fault. Ageing a zero counter would wrap it to the maximum, and forgetting the OR-reload would leave the used way looking old. Lookups with one of the enable bits cleared catch a design that translates anyway. A write issued in the same cycle as a hit on the same entry catches a design that lets the counter update win over software. Misses are followed by readback to show that a miss leaves every entry untouched.

// File: rtl/itlb_pkg.sv
package itlb_pkg;
  typedef enum logic [1:0] {
    RES_PASS  = 2'd0,
    RES_HIT   = 2'd1,
    RES_MISS  = 2'd2,
    RES_FAULT = 2'd3
  } resKind_e;

  // Control-to-datapath strobes for one lookup
  typedef struct packed {
    logic     fire;
    resKind_e kind;
    logic [1:0] way;
  } lkStrobe_t;
endpackage

// File: rtl/itlb_ctrl.sv
module itlb_ctrl
  import itlb_pkg::*;
#(
  parameter int NWAYS = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lookupReq,
  input  logic             transEn,
  input  logic             mmuPresent,
  input  logic             supervisor,
  input  logic [NWAYS-1:0] matchVec,
  input  logic [NWAYS-1:0] sxVec,
  input  logic [NWAYS-1:0] uxVec,
  input  logic [NWAYS-1:0] ciVec,
  output lkStrobe_t        strb,
  output logic             lookupValid,
  output logic             hit,
  output logic             miss,
  output logic             pageFault,
  output logic             cacheInhibit
);
  logic [1:0] wayIdx;
  logic       permOk;
  resKind_e   kind;

  // Lowest-numbered matching way wins (R8)
  always_comb begin
    wayIdx = 2'd0;
    for (int w = NWAYS - 1; w >= 0; w--) begin
      if (matchVec[w]) wayIdx = 2'(w);
    end
  end

  assign permOk = supervisor ? sxVec[wayIdx] : uxVec[wayIdx];

  always_comb begin
    if (!(transEn && mmuPresent)) kind = RES_PASS;
    else if (matchVec == '0)      kind = RES_MISS;
    else if (permOk)              kind = RES_HIT;
    else                          kind = RES_FAULT;
  end

  assign strb = '{fire: lookupReq, kind: kind, way: wayIdx};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lookupValid  <= 1'b0;
      hit          <= 1'b0;
      miss         <= 1'b0;
      pageFault    <= 1'b0;
      cacheInhibit <= 1'b0;
    end else begin
      lookupValid  <= lookupReq;
      hit          <= lookupReq && (kind == RES_HIT);
      miss         <= lookupReq && (kind == RES_MISS);
      pageFault    <= lookupReq && (kind == RES_FAULT);
      cacheInhibit <= lookupReq && (kind == RES_HIT) && ciVec[wayIdx];
    end
  end

  p_single_outcome_r11: assert property (@(posedge clk) disable iff (!rstN)
    lookupValid |-> $onehot0({hit, miss, pageFault}));
  p_valid_follows_req_r11: assert property (@(posedge clk) disable iff (!rstN)
    lookupReq |=> lookupValid);
  p_ci_needs_hit_r6: assert property (@(posedge clk) disable iff (!rstN)
    cacheInhibit |-> (hit && lookupValid));
endmodule

// File: rtl/itlb_dp.sv
module itlb_dp
  import itlb_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 13,
  parameter int NSETS     = 8,
  parameter int NWAYS     = 2,
  parameter int LRU_W     = 2,
  localparam int SET_W    = $clog2(NSETS),
  localparam int WAY_W    = (NWAYS > 1) ? $clog2(NWAYS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] vaddr,
  input  lkStrobe_t         strb,
  input  logic              regWe,
  input  logic              regSel,
  input  logic [WAY_W-1:0]  regWay,
  input  logic [SET_W-1:0]  regSet,
  input  logic [ADDR_W-1:0] regWdata,
  output logic [ADDR_W-1:0] regRdata,
  output logic [NWAYS-1:0]  matchVec,
  output logic [NWAYS-1:0]  sxVec,
  output logic [NWAYS-1:0]  uxVec,
  output logic [NWAYS-1:0]  ciVec,
  output logic [ADDR_W-1:0] paddr
);
  localparam int TAG_W = ADDR_W - PAGE_BITS - SET_W;
  localparam int PPN_W = ADDR_W - PAGE_BITS;
  localparam logic [LRU_W-1:0] RELOAD = LRU_W'(NSETS - 1);

  logic [TAG_W-1:0] tagQ   [NWAYS][NSETS];
  logic             validQ [NWAYS][NSETS];
  logic [LRU_W-1:0] lruQ   [NWAYS][NSETS];
  logic [PPN_W-1:0] ppnQ   [NWAYS][NSETS];
  logic             ciQ    [NWAYS][NSETS];
  logic             sxQ    [NWAYS][NSETS];
  logic             uxQ    [NWAYS][NSETS];

  logic [SET_W-1:0] lkSet;
  logic [TAG_W-1:0] lkTag;
  logic [WAY_W-1:0] selWay;
  logic             ageSet;

  assign lkSet  = vaddr[PAGE_BITS +: SET_W];
  assign lkTag  = vaddr[ADDR_W-1 -: TAG_W];
  assign selWay = strb.way[WAY_W-1:0];
  assign ageSet = strb.fire && (strb.kind == RES_HIT || strb.kind == RES_FAULT);

  for (genvar w = 0; w < NWAYS; w++) begin : g_way
    assign matchVec[w] = validQ[w][lkSet] && (tagQ[w][lkSet] == lkTag);
    assign sxVec[w]    = sxQ[w][lkSet];
    assign uxVec[w]    = uxQ[w][lkSet];
    assign ciVec[w]    = ciQ[w][lkSet];
  end

  function automatic logic [LRU_W-1:0] agedLru(logic [LRU_W-1:0] cur, logic used);
    logic [LRU_W-1:0] d;
    d = (cur != '0) ? cur - 1'b1 : cur;
    return used ? (d | RELOAD) : d;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int w = 0; w < NWAYS; w++) begin
        for (int s = 0; s < NSETS; s++) begin
          tagQ[w][s]   <= '0;
          validQ[w][s] <= 1'b0;
          lruQ[w][s]   <= '0;
          ppnQ[w][s]   <= '0;
          ciQ[w][s]    <= 1'b0;
          sxQ[w][s]    <= 1'b0;
          uxQ[w][s]    <= 1'b0;
        end
      end
      paddr <= '0;
    end else begin
      if (ageSet) begin
        for (int w = 0; w < NWAYS; w++) begin
          lruQ[w][lkSet] <= agedLru(lruQ[w][lkSet], WAY_W'(w) == selWay);
        end
      end
      // Software write comes last so it overrides ageing (R9)
      if (regWe) begin
        if (!regSel) begin
          tagQ[regWay][regSet]   <= regWdata[ADDR_W-1 -: TAG_W];
          lruQ[regWay][regSet]   <= regWdata[LRU_W:1];
          validQ[regWay][regSet] <= regWdata[0];
        end else begin
          ppnQ[regWay][regSet] <= regWdata[ADDR_W-1 -: PPN_W];
          uxQ[regWay][regSet]  <= regWdata[2];
          sxQ[regWay][regSet]  <= regWdata[1];
          ciQ[regWay][regSet]  <= regWdata[0];
        end
      end
      if (strb.fire) begin
        case (strb.kind)
          RES_HIT:   paddr <= {ppnQ[selWay][lkSet], vaddr[PAGE_BITS-1:0]};
          RES_FAULT: paddr <= '0;
          default:   paddr <= vaddr;
        endcase
      end
    end
  end

  always_comb begin
    regRdata = '0;
    if (!regSel) begin
      regRdata[ADDR_W-1 -: TAG_W] = tagQ[regWay][regSet];
      regRdata[LRU_W:1]           = lruQ[regWay][regSet];
      regRdata[0]                 = validQ[regWay][regSet];
    end else begin
      regRdata[ADDR_W-1 -: PPN_W] = ppnQ[regWay][regSet];
      regRdata[2]                 = uxQ[regWay][regSet];
      regRdata[1]                 = sxQ[regWay][regSet];
      regRdata[0]                 = ciQ[regWay][regSet];
    end
  end

  p_used_way_reloaded_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ageSet && !regWe) |=> (lruQ[$past(selWay)][$past(lkSet)] != '0));
endmodule

// File: rtl/itlb_lookup.sv
module itlb_lookup
  import itlb_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 13,
  parameter int NSETS     = 8,
  parameter int NWAYS     = 2,
  parameter int LRU_W     = 2,
  localparam int SET_W    = $clog2(NSETS),
  localparam int WAY_W    = (NWAYS > 1) ? $clog2(NWAYS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lookupReq,
  input  logic [ADDR_W-1:0] vaddr,
  input  logic              transEn,
  input  logic              mmuPresent,
  input  logic              supervisor,
  input  logic              regWe,
  input  logic              regSel,
  input  logic [WAY_W-1:0]  regWay,
  input  logic [SET_W-1:0]  regSet,
  input  logic [ADDR_W-1:0] regWdata,
  output logic [ADDR_W-1:0] regRdata,
  output logic              lookupValid,
  output logic              hit,
  output logic              miss,
  output logic              pageFault,
  output logic              cacheInhibit,
  output logic [ADDR_W-1:0] paddr
);
  initial begin
    assert (NWAYS >= 1 && NWAYS <= 4);
    assert (NSETS >= 2 && NSETS <= 256 && (NSETS & (NSETS - 1)) == 0);
    assert (LRU_W + 1 <= PAGE_BITS);
  end

  lkStrobe_t        strb;
  logic [NWAYS-1:0] matchVec, sxVec, uxVec, ciVec;

  itlb_ctrl #(.NWAYS(NWAYS)) i_ctrl (
    .clk(clk), .rstN(rstN), .lookupReq(lookupReq), .transEn(transEn),
    .mmuPresent(mmuPresent), .supervisor(supervisor), .matchVec(matchVec),
    .sxVec(sxVec), .uxVec(uxVec), .ciVec(ciVec), .strb(strb),
    .lookupValid(lookupValid), .hit(hit), .miss(miss),
    .pageFault(pageFault), .cacheInhibit(cacheInhibit)
  );

  itlb_dp #(
    .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .NSETS(NSETS),
    .NWAYS(NWAYS), .LRU_W(LRU_W)
  ) i_dp (
    .clk(clk), .rstN(rstN), .vaddr(vaddr), .strb(strb), .regWe(regWe),
    .regSel(regSel), .regWay(regWay), .regSet(regSet), .regWdata(regWdata),
    .regRdata(regRdata), .matchVec(matchVec), .sxVec(sxVec), .uxVec(uxVec),
    .ciVec(ciVec), .paddr(paddr)
  );

  p_miss_reports_vaddr_r4: assert property (@(posedge clk) disable iff (!rstN)
    miss |-> (paddr == $past(vaddr)));
  p_bypass_identity_r1: assert property (@(posedge clk) disable iff (!rstN)
    (lookupValid && !hit && !miss && !pageFault) |-> (paddr == $past(vaddr)));
  p_fault_zero_addr_r5: assert property (@(posedge clk) disable iff (!rstN)
    pageFault |-> (paddr == '0));
endmodule

// File: tb/test_itlb_lookup.sv
module test_itlb_lookup;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lookupReq = 1'b0;
  logic [31:0] vaddr = '0;
  logic        transEn = 1'b0, mmuPresent = 1'b0, supervisor = 1'b0;
  logic        regWe = 1'b0, regSel = 1'b0;
  logic [0:0]  regWay = '0;
  logic [2:0]  regSet = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata, paddr;
  logic        lookupValid, hit, miss, pageFault, cacheInhibit;

  int nChecks = 0;
  int nFails  = 0;

  // Model state: 2 ways, 8 sets, 16-bit tag, 19-bit page number, 2-bit counter
  int unsigned mTag [2][8];
  bit          mV   [2][8];
  int unsigned mLru [2][8];
  int unsigned mPpn [2][8];
  bit          mCi  [2][8];
  bit          mSx  [2][8];
  bit          mUx  [2][8];

  always #2 clk = ~clk;

  itlb_lookup i_itlb_lookup (
    .clk(clk), .rstN(rstN), .lookupReq(lookupReq), .vaddr(vaddr),
    .transEn(transEn), .mmuPresent(mmuPresent), .supervisor(supervisor),
    .regWe(regWe), .regSel(regSel), .regWay(regWay), .regSet(regSet),
    .regWdata(regWdata), .regRdata(regRdata), .lookupValid(lookupValid),
    .hit(hit), .miss(miss), .pageFault(pageFault),
    .cacheInhibit(cacheInhibit), .paddr(paddr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] matchWord(int w, int s);
    return (mTag[w][s] << 16) | (mLru[w][s] << 1) | 32'(mV[w][s]);
  endfunction

  function automatic logic [31:0] transWord(int w, int s);
    return (mPpn[w][s] << 13) | (32'(mUx[w][s]) << 2) | (32'(mSx[w][s]) << 1) | 32'(mCi[w][s]);
  endfunction

  function automatic void modelWrite(bit sel, int w, int s, logic [31:0] d);
    if (!sel) begin
      mTag[w][s] = d[31:16]; mLru[w][s] = d[2:1]; mV[w][s] = d[0];
    end else begin
      mPpn[w][s] = d[31:13]; mUx[w][s] = d[2]; mSx[w][s] = d[1]; mCi[w][s] = d[0];
    end
  endfunction

  task automatic regWrite(input bit sel, input int w, input int s, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regSel = sel; regWay = 1'(w); regSet = 3'(s); regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
    modelWrite(sel, w, s, d);
  endtask

  task automatic readCheck(input string req, input bit sel, input int w, input int s);
    @(negedge clk);
    regSel = sel; regWay = 1'(w); regSet = 3'(s);
    #1;
    chk(req, regRdata, sel ? transWord(w, s) : matchWord(w, s));
  endtask

  // One lookup; optionally a same-cycle register write to a tag word
  task automatic lookup(input logic [31:0] va, input bit en, input bit pres, input bit sup,
                        input bit wrAlso, input int wrWay, input logic [31:0] wrData);
    int s, hw;
    bit perm, aged;
    s  = int'(va[15:13]);
    hw = -1;
    for (int w = 1; w >= 0; w--)
      if (mV[w][s] && mTag[w][s] == int'(va[31:16])) hw = w;   // lowest way wins (R8)
    @(negedge clk);
    lookupReq = 1'b1; vaddr = va; transEn = en; mmuPresent = pres; supervisor = sup;
    if (wrAlso) begin
      regWe = 1'b1; regSel = 1'b0; regWay = 1'(wrWay); regSet = 3'(s); regWdata = wrData;
    end
    @(posedge clk); #1;
    chk("R11 valid", 32'(lookupValid), 32'd1);
    aged = 1'b0;
    if (!(en && pres)) begin
      chk("R1 flags", {29'd0, hit, miss, pageFault}, 32'd0);
      chk("R1 paddr", paddr, va);
      chk("R1 ci", 32'(cacheInhibit), 32'd0);
    end else if (hw < 0) begin
      chk("R4 miss", {29'd0, hit, miss, pageFault}, 32'b010);
      chk("R4 paddr", paddr, va);
    end else begin
      perm = sup ? mSx[hw][s] : mUx[hw][s];
      aged = 1'b1;
      if (perm) begin
        chk("R2 hit", {29'd0, hit, miss, pageFault}, 32'b100);
        chk("R3 paddr", paddr, (mPpn[hw][s] << 13) | (va & 32'h1fff));
        chk("R6 ci", 32'(cacheInhibit), 32'(mCi[hw][s]));
      end else begin
        chk("R5 fault", {29'd0, hit, miss, pageFault}, 32'b001);
        chk("R5 paddr", paddr, 32'd0);
        chk("R6 ci on fault", 32'(cacheInhibit), 32'd0);
      end
    end
    if (aged) begin
      for (int w = 0; w < 2; w++) begin
        if (mLru[w][s] != 0) mLru[w][s]--;
        if (w == hw) mLru[w][s] |= 3;   // (8-1) truncated to 2 bits
      end
    end
    @(negedge clk);
    lookupReq = 1'b0;
    if (wrAlso) begin
      regWe = 1'b0;
      modelWrite(1'b0, wrWay, s, wrData);
    end
    chk("R11 pulse", 32'(lookupValid), 32'd1);
    #3;
    chk("R11 single cycle", 32'(lookupValid), 32'd0);
    readCheck(aged ? "R7 way0" : "R4 way0 unchanged", 1'b0, 0, s);
    readCheck(aged ? "R7 way1" : "R4 way1 unchanged", 1'b0, 1, s);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL R11 watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    int unsigned seedDummy;
    seedDummy = $urandom(32'd4711);
    for (int w = 0; w < 2; w++)
      for (int s = 0; s < 8; s++) begin
        mTag[w][s] = 0; mV[w][s] = 0; mLru[w][s] = 0; mPpn[w][s] = 0;
        mCi[w][s] = 0; mSx[w][s] = 0; mUx[w][s] = 0;
      end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    chk("R10 no lookup after reset", 32'(lookupValid), 32'd0);
    for (int w = 0; w < 2; w++)
      for (int s = 0; s < 8; s++) readCheck("R10 cleared", 1'b0, w, s);

    // Duplicate tags in set 2: way0 must win (R8)
    regWrite(1'b0, 0, 2, (32'h0011 << 16) | (0 << 1) | 1);
    regWrite(1'b1, 0, 2, (32'h12345 << 13) | 32'b011);
    regWrite(1'b0, 1, 2, (32'h0011 << 16) | (2 << 1) | 1);
    regWrite(1'b1, 1, 2, (32'h54321 << 13) | 32'b110);
    readCheck("R9 translate readback", 1'b1, 1, 2);
    lookup({16'h0011, 3'd2, 13'h0abc}, 1, 1, 1, 0, 0, 0);   // R8 supervisor hit way0
    lookup({16'h0011, 3'd2, 13'h1234}, 1, 1, 0, 0, 0, 0);   // R5 user fault on way0
    lookup({16'h0011, 3'd2, 13'h0004}, 0, 1, 1, 0, 0, 0);   // R1 disabled
    lookup({16'h0011, 3'd2, 13'h0008}, 1, 0, 1, 0, 0, 0);   // R1 absent
    lookup({16'h0099, 3'd2, 13'h0010}, 1, 1, 1, 0, 0, 0);   // R4 miss
    lookup({16'h0011, 3'd3, 13'h0010}, 1, 1, 1, 0, 0, 0);   // R2 other set misses
    // R9: write in the same cycle as a hit on that entry wins
    lookup({16'h0011, 3'd2, 13'h0020}, 1, 1, 1, 1, 0, (32'h0011 << 16) | 1);
    readCheck("R9 write over ageing", 1'b0, 0, 2);

    // Random fill and mixed traffic
    for (int w = 0; w < 2; w++)
      for (int s = 0; s < 8; s++) begin
        regWrite(1'b0, w, s, (((($urandom % 3) + 1)) << 16) | (($urandom % 4) << 1) |
                 32'(($urandom % 5) != 0));
        regWrite(1'b1, w, s, (($urandom % 32'h80000) << 13) | ($urandom % 8));
      end
    for (int i = 0; i < 400; i++) begin
      int r;
      r = int'($urandom % 10);
      if (r < 2) begin
        regWrite(1'b0, int'($urandom % 2), int'($urandom % 8),
                 ((($urandom % 3) + 1) << 16) | (($urandom % 4) << 1) | 32'(($urandom % 4) != 0));
      end else if (r == 2) begin
        regWrite(1'b1, int'($urandom % 2), int'($urandom % 8),
                 (($urandom % 32'h80000) << 13) | ($urandom % 8));
      end else begin
        logic [31:0] va;
        va = {16'(($urandom % 4) + 1), 3'($urandom), 13'($urandom)};
        lookup(va, ($urandom % 10) != 0, ($urandom % 10) != 0, 1'($urandom), 0, 0, 0);
      end
    end
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule